// File: doc/BRIEF.md
# Stall-Tolerant Scan Wrapper Controller

This block sequences the scan test of one embedded core whose test stimulus arrives as 32-bit flits over an on-chip network, and whose responses leave the same way. Links on that network may retransmit, so flits can arrive late and the outgoing path can back up. The controller turns the flit stream into one scan bit per scan clock, gathers the bits the core shifts out back into flits, and runs a repeating pattern of a fixed number of shift cycles followed by a single capture cycle.

The scan clock is a divided and gated copy of the network clock. When the next scan bit is not yet on hand, the controller parks in an input-stall state; when the response side has no room left, it parks in an output-stall state. In both, the scan clock stays low and scan enable stays at its shift value, so the core neither loses, repeats nor spuriously captures a bit. Two stall indications tell the surrounding buffer logic which side is holding the core.

Top module: `scan_wrap_ctl`

## Requirements
- R1: After a synchronous reset, scan_clk, scan_en, stall_in, stall_out and out_valid are 0 and in_accept is 1.
- R2: Each scan cycle lasts SCAN_DIV clock cycles; in a running cycle scan_clk is low for the first SCAN_DIV/2 clocks and high for the rest, giving exactly one rising edge per scan cycle.
- R3: With test_en low the controller stays idle (scan_en 0, no scan_clk edge); it starts a pattern when test_en is high, and a drop of test_en takes effect only after the next capture cycle, after which it is idle again.
- R4: A pattern is CHAIN_LEN shift cycles (scan_en 1 at the scan_clk edge) followed by exactly one capture cycle (scan_en 0 at the scan_clk edge).
- R5: Input flit bits are driven onto scan_si least significant bit first, in arrival order, each bit used in exactly one shift cycle.
- R6: The scan_so value present at the start of each shift cycle is collected; every FLIT_W such bits form an output flit, the first collected bit in bit 0. out_valid stays high with out_flit unchanged until out_ready is seen high.
- R7: in_accept is high exactly when the one-flit staging register is empty; a flit is taken on a clock edge where in_valid and in_accept are both high.
- R8: If no scan bit is on hand when a shift cycle is due, the controller enters the input-stall state: stall_in 1, scan_en 1, scan_clk low, until a bit is available.
- R9: If the response side is full (a complete flit waiting unaccepted plus a full collecting register) when a shift cycle is due, the controller enters the output-stall state: stall_out 1, scan_en 1, scan_clk low.
- R10: When both sides are blocked, input stall wins; clearing the input side alone then moves the controller to the output stall, and shifting resumes only once both have cleared. stall_in and stall_out are never both 1.
- R11: A capture cycle is never replaced by a stall: after the last shift bit of a pattern the capture cycle runs even when the input is empty; a stall then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Run scan patterns |
| in_valid | input | 1 | Incoming flit present |
| in_flit | input | FLIT_W | Incoming stimulus flit |
| in_accept | output | 1 | Staging register free, flit taken when in_valid is high |
| out_valid | output | 1 | Response flit present |
| out_flit | output | FLIT_W | Response flit |
| out_ready | input | 1 | Downstream takes the response flit |
| scan_clk | output | 1 | Divided, gated scan clock |
| scan_en | output | 1 | 1 = shift, 0 = capture |
| scan_si | output | 1 | Scan data to the core |
| scan_so | input | 1 | Scan data from the core |
| stall_in | output | 1 | Held for lack of stimulus |
| stall_out | output | 1 | Held for lack of response room |

## Verification
The assertions assume that out_flit only needs to be stable while out_valid is held, and that stall entry is judged against the handshake state of the cycle before, since a flit may be taken or released on the very edge a stall begins. The stimulus feeds whole flits only and keeps the core model a plain shift register that inverts itself on capture, so the expected responses follow from the bit order alone, independent of when stalls happen. Flit counts are chosen so that the input runs dry exactly at a pattern end and exactly when the response side fills, which puts the capture-versus-stall and the input-versus-output priority cases on the same scan cycle.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_CAPT   = 3'd2,
    ST_STARVE = 3'd3,
    ST_BACKUP = 3'd4
  } wst_t;
endpackage

// File: rtl/swc_phase.sv
module swc_phase #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic hi_next
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [PW-1:0] ph;
  logic [PW-1:0] ph_nxt;

  assign tick    = (ph == PW'(DIV - 1));
  assign ph_nxt  = tick ? '0 : ph + 1'b1;
  assign hi_next = (ph_nxt >= PW'(HALF));

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph_nxt;
  end
endmodule

// File: rtl/swc_inbuf.sv
module swc_inbuf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_accept,
  input  logic         pop,
  output logic         bit_out,
  output logic         avail
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  pend, pend_n, shr, shr_n;
  logic          pend_v, pend_v_n;
  logic [CW-1:0] scnt, scnt_n;
  logic          take;

  assign in_accept = !pend_v;
  assign take      = in_valid && !pend_v;
  assign avail     = (scnt != '0) || pend_v;
  assign bit_out   = (scnt != '0) ? shr[0] : pend[0];

  always_comb begin
    shr_n    = shr;
    scnt_n   = scnt;
    pend_n   = pend;
    pend_v_n = pend_v;
    if (scnt != '0) begin
      if (pop) begin
        shr_n  = shr >> 1;
        scnt_n = scnt - 1'b1;
      end
    end else if (pend_v) begin
      pend_v_n = 1'b0;
      if (pop) begin
        shr_n  = pend >> 1;
        scnt_n = CW'(W - 1);
      end else begin
        shr_n  = pend;
        scnt_n = CW'(W);
      end
    end
    if (take) begin
      pend_n   = in_data;
      pend_v_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      pend_v <= 1'b0;
      shr    <= '0;
      scnt   <= '0;
    end else begin
      pend   <= pend_n;
      pend_v <= pend_v_n;
      shr    <= shr_n;
      scnt   <= scnt_n;
    end
  end
endmodule

// File: rtl/swc_outbuf.sv
module swc_outbuf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         bit_in,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         full
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  oshr;
  logic [CW-1:0] ocnt;
  logic [W-1:0]  hold;
  logic          hold_v;
  logic          move;

  assign move      = (ocnt == CW'(W)) && !hold_v;
  assign full      = (ocnt == CW'(W)) && hold_v;
  assign out_valid = hold_v;
  assign out_data  = hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      oshr   <= '0;
      ocnt   <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
    end else begin
      if (push) oshr <= {bit_in, oshr[W-1:1]};
      if (move)      ocnt <= push ? CW'(1) : '0;
      else if (push) ocnt <= ocnt + 1'b1;
      if (move) begin
        hold   <= oshr;
        hold_v <= 1'b1;
      end else if (hold_v && out_ready) begin
        hold_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swc_seq.sv
module swc_seq
  import scan_wrap_pkg::*;
#(
  parameter int CHAIN_LEN = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic test_en,
  input  logic in_avail,
  input  logic out_full,
  output wst_t st_nxt,
  output logic shift_go
);
  localparam int CW = $clog2(CHAIN_LEN + 1);

  wst_t          st, decided, resume;
  logic [CW-1:0] shcnt;
  logic          pat_done;

  assign pat_done = (shcnt == CW'(CHAIN_LEN));

  always_comb begin
    if (!in_avail)     resume = ST_STARVE;
    else if (out_full) resume = ST_BACKUP;
    else               resume = ST_SHIFT;
  end

  always_comb begin
    decided = st;
    case (st)
      ST_IDLE:  decided = test_en ? resume : ST_IDLE;
      ST_SHIFT, ST_STARVE, ST_BACKUP:
                decided = pat_done ? ST_CAPT : resume;
      ST_CAPT:  decided = test_en ? resume : ST_IDLE;
      default:  decided = ST_IDLE;
    endcase
  end

  assign st_nxt   = tick ? decided : st;
  assign shift_go = tick && (decided == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      shcnt <= '0;
    end else begin
      st <= st_nxt;
      if (shift_go)                       shcnt <= shcnt + 1'b1;
      else if (tick && decided == ST_CAPT) shcnt <= '0;
    end
  end
endmodule

// File: rtl/scan_wrap_ctl.sv
module scan_wrap_ctl
  import scan_wrap_pkg::*;
#(
  parameter int FLIT_W    = 32,
  parameter int SCAN_DIV  = 4,
  parameter int CHAIN_LEN = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_en,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_accept,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  input  logic              out_ready,
  output logic              scan_clk,
  output logic              scan_en,
  output logic              scan_si,
  input  logic              scan_so,
  output logic              stall_in,
  output logic              stall_out
);
  logic tick, hi_next;
  logic in_bit, in_avail, out_full, shift_go;
  wst_t st_nxt;
  logic sclk_q, sen_q, ssi_q, stin_q, stout_q;

  swc_phase #(.DIV(SCAN_DIV)) u_phase (
    .clk(clk), .rst(rst), .tick(tick), .hi_next(hi_next)
  );

  swc_inbuf #(.W(FLIT_W)) u_inbuf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_flit),
    .in_accept(in_accept), .pop(shift_go), .bit_out(in_bit), .avail(in_avail)
  );

  swc_outbuf #(.W(FLIT_W)) u_outbuf (
    .clk(clk), .rst(rst), .push(shift_go), .bit_in(scan_so),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_flit),
    .full(out_full)
  );

  swc_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .test_en(test_en),
    .in_avail(in_avail), .out_full(out_full),
    .st_nxt(st_nxt), .shift_go(shift_go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sen_q   <= 1'b0;
      ssi_q   <= 1'b0;
      stin_q  <= 1'b0;
      stout_q <= 1'b0;
    end else begin
      sclk_q  <= ((st_nxt == ST_SHIFT) || (st_nxt == ST_CAPT)) && hi_next;
      sen_q   <= (st_nxt == ST_SHIFT) || (st_nxt == ST_STARVE) ||
                 (st_nxt == ST_BACKUP);
      stin_q  <= (st_nxt == ST_STARVE);
      stout_q <= (st_nxt == ST_BACKUP);
      if (shift_go) ssi_q <= in_bit;
    end
  end

  assign scan_clk  = sclk_q;
  assign scan_en   = sen_q;
  assign scan_si   = ssi_q;
  assign stall_in  = stin_q;
  assign stall_out = stout_q;
endmodule

// File: rtl/scan_wrap_ctl_chk.sv
module scan_wrap_ctl_chk #(
  parameter int FLIT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_accept,
  input logic              out_valid,
  input logic [FLIT_W-1:0] out_flit,
  input logic              out_ready,
  input logic              scan_clk,
  input logic              scan_en,
  input logic              stall_in,
  input logic              stall_out
);
  a_r8_stall_gates_clk: assert property (@(posedge clk) disable iff (rst)
    (stall_in || stall_out) |-> !scan_clk);

  a_r8_stall_keeps_shift: assert property (@(posedge clk) disable iff (rst)
    (stall_in || stall_out) |-> scan_en);

  a_r10_single_stall: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stall_in, stall_out}));

  a_r6_out_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

  a_r8_starve_when_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_in) |-> $past(in_accept));

  a_r9_backup_when_full: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_out) |-> $past(out_valid));
endmodule

bind scan_wrap_ctl scan_wrap_ctl_chk #(.FLIT_W(FLIT_W)) u_chk (.*);

// File: tb/scan_wrap_ctl_tb.sv
module scan_wrap_ctl_tb;
  localparam int W   = 32;
  localparam int DIV = 4;
  localparam int L   = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_en = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_flit = '0;
  logic in_accept, out_valid, out_ready, scan_clk, scan_en, scan_si;
  logic scan_so, stall_in, stall_out;
  logic [W-1:0] out_flit;

  always #2 clk = ~clk;

  scan_wrap_ctl #(.FLIT_W(W), .SCAN_DIV(DIV), .CHAIN_LEN(L)) u_dut (
    .clk(clk), .rst(rst), .test_en(test_en), .in_valid(in_valid),
    .in_flit(in_flit), .in_accept(in_accept), .out_valid(out_valid),
    .out_flit(out_flit), .out_ready(out_ready), .scan_clk(scan_clk),
    .scan_en(scan_en), .scan_si(scan_si), .scan_so(scan_so),
    .stall_in(stall_in), .stall_out(stall_out)
  );

  // core model: shift on scan_en, invert whole chain on capture
  logic [L-1:0] core = '0;
  always_ff @(posedge scan_clk) begin
    if (scan_en) core <= {core[L-2:0], scan_si};
    else         core <= ~core;
  end
  assign scan_so = core[L-1];

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference of the chain, fed bit by bit
  logic [L-1:0] rchain = '0;
  int rcnt = 0;
  logic [W-1:0] expq[$];

  task automatic send(input logic [W-1:0] f, input bit do_exp);
    logic [W-1:0] e;
    e = '0;
    for (int k = 0; k < W; k++) begin
      e[k]   = rchain[L-1];
      rchain = {rchain[L-2:0], f[k]};
      rcnt++;
      if (rcnt == L) begin
        rchain = ~rchain;
        rcnt   = 0;
      end
    end
    if (do_exp) expq.push_back(e);
    @(negedge clk);
    in_valid = 1'b1;
    in_flit  = f;
    while (!in_accept) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor for response flits
  int n_got = 0;
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      n_got++;
      if (expq.size() == 0) begin
        chk(1'b0, "R6 unexpected flit", 64'(out_flit), 64'd0);
      end else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        chk(out_flit == e, "R5/R6 response flit", 64'(out_flit), 64'(e));
      end
    end
  end

  // scan clock pulse monitor
  logic prev_sclk = 1'b0;
  int   hi_len = 0;
  int   width_err = 0;
  int   shift_run = 0;
  int   n_pulse = 0;
  bit   last_en = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (scan_clk) hi_len++;
      if (scan_clk && !prev_sclk) begin
        n_pulse++;
        last_en = scan_en;
        if (scan_en) shift_run++;
        else begin
          chk(shift_run == L, "R4 shifts before capture", 64'(shift_run), 64'(L));
          shift_run = 0;
        end
      end
      if (!scan_clk && prev_sclk) begin
        if (hi_len != DIV - DIV / 2) width_err++;
        hi_len = 0;
      end
    end
    prev_sclk = scan_clk;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic quiet_window(input string tag);
    int p0;
    bit bad;
    p0 = n_pulse;
    bad = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (scan_clk) bad = 1'b1;
    end
    chk(!bad && n_pulse == p0, tag, 64'(n_pulse - p0), 64'd0);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 20000 && (expq.size() != 0 || !stall_in); i++)
      @(negedge clk);
  endtask

  initial begin
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({scan_clk, scan_en, stall_in, stall_out, out_valid, in_accept} == 6'b000001,
        "R1 reset outputs",
        64'({scan_clk, scan_en, stall_in, stall_out, out_valid, in_accept}), 64'b1);

    // R3 idle while test_en is low
    quiet_window("R3 idle no scan clock");
    chk(scan_en == 1'b0, "R3 idle scan_en", 64'(scan_en), 64'd0);

    // main stream: 6 flits = 4 whole patterns
    test_en = 1'b1;
    send(32'h1234_5678, 1'b1);
    send(32'hFFFF_0000, 1'b1);
    send(32'hA5A5_A5A5, 1'b1);
    send(32'h0000_0001, 1'b1);
    send(32'h8000_0000, 1'b1);
    send(32'hDEAD_BEEF, 1'b1);
    wait_drain();
    chk(n_got == 6, "R5/R6 flits returned", 64'(n_got), 64'd6);
    // R11: input ran dry exactly at a pattern end; capture still happened
    chk(last_en == 1'b0, "R11 capture ran before stall", 64'(last_en), 64'd0);
    chk(shift_run == 0, "R11 no shift after capture", 64'(shift_run), 64'd0);
    // R8 input stall
    chk(stall_in && !stall_out && scan_en, "R8 input stall state",
        64'({stall_in, stall_out, scan_en}), 64'b101);
    quiet_window("R8 clock gated in input stall");
    chk(width_err == 0, "R2 scan clock high width", 64'(width_err), 64'd0);

    // R9 output stall with input still available
    out_ready = 1'b0;
    send(32'h0F0F_0F0F, 1'b1);
    send(32'h3C3C_C3C3, 1'b1);
    send(32'h7777_1111, 1'b1);
    for (int i = 0; i < 3000 && !stall_out; i++) @(negedge clk);
    chk(stall_out && !stall_in && scan_en, "R9 output stall state",
        64'({stall_in, stall_out, scan_en}), 64'b011);
    send(32'h2468_ACE0, 1'b1);
    @(negedge clk);
    chk(in_accept == 1'b0, "R7 staging full blocks accept", 64'(in_accept), 64'd0);
    chk(out_valid == 1'b1, "R6 flit held without ready", 64'(out_valid), 64'd1);
    quiet_window("R9 clock gated in output stall");
    out_ready = 1'b1;
    wait_drain();
    chk(n_got == 10, "R9 flits after release", 64'(n_got), 64'd10);

    // R10 both blocked on the same scan cycle
    out_ready = 1'b0;
    send(32'h1357_9BDF, 1'b1);
    send(32'hFEDC_BA98, 1'b1);
    for (int i = 0; i < 3000 && !(stall_in && out_valid && shift_run == 0 && n_pulse > 0); i++)
      @(negedge clk);
    repeat (40) @(negedge clk);
    chk(stall_in && !stall_out, "R10 input stall wins",
        64'({stall_in, stall_out}), 64'b10);
    send(32'h5555_AAAA, 1'b1);
    for (int i = 0; i < 200 && !stall_out; i++) @(negedge clk);
    chk(stall_out && !stall_in, "R10 still held by output side",
        64'({stall_in, stall_out}), 64'b01);
    quiet_window("R10 no shift while output blocked");
    out_ready = 1'b1;
    wait_drain();
    chk(n_got == 13, "R10 flits after release", 64'(n_got), 64'd13);

    // R3 stop: drop test_en mid pattern; pattern completes then idles
    test_en = 1'b0;
    send(32'h0BAD_F00D, 1'b0);
    for (int i = 0; i < 2000 && scan_en; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(!scan_en && !stall_in && !stall_out, "R3 idle after stop",
        64'({scan_en, stall_in, stall_out}), 64'd0);
    chk(last_en == 1'b0, "R3 stop after capture", 64'(last_en), 64'd0);
    chk(in_accept == 1'b1, "R7 accept with staging empty", 64'(in_accept), 64'd1);
    quiet_window("R3 no scan clock after stop");
    chk(width_err == 0, "R2 scan clock high width final", 64'(width_err), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule